// File: doc/BRIEF.md
# Speculative Wakeup-Select Issue Queue

This block holds up to N renamed instructions and picks, each cycle, up to W of them for issue. Each slot keeps two source tags with ready bits, a destination tag and a load flag. A slot asks for issue once both sources are ready. An age-ordered selector grants the oldest requesters. The destination tag of a granted non-load goes out on the wakeup bus in the same cycle, so a dependent can go in the very next cycle.

Loads are scheduled as if they always hit. Their tags are broadcast a fixed LOAD_LAT cycles after selection through a short delay line. When the memory side reports a miss, MISS_DELAY cycles after the load was selected, the queue replays without tracking dependences. Every instruction selected in the cycles after the load goes back to waiting. Readiness that came from the missed tag, or from a replayed producer, is withdrawn. A later resolve broadcast brings it back. To allow this, slots stay occupied until the miss window of their own selection has closed.

Top module: `spec_issue_queue`

## Requirements
- R1: After a synchronous reset, no lane of `iss_valid` is set and `iq_full` is low.
- R2: A slot is selected only when both of its source ready bits are set. An instruction dispatched in cycle k with both sources ready is selected in cycle k+1 and is shown on the issue port in cycle k+2, since the port is registered.
- R3: At most W slots are selected per cycle, in dispatch order. Lanes fill from lane 0 upward, and lane 0 carries the oldest. Lane l occupies `iss_tag[l*TAG_W +: TAG_W]`.
- R4: A non-load broadcasts its destination tag in its selection cycle. A dependent whose other source is ready is then selected in the next cycle.
- R5: A source whose tag matches a broadcast in the cycle it is dispatched is captured as ready.
- R6: A load broadcasts its destination tag LOAD_LAT-1 cycles after its selection. A dependent is therefore selected LOAD_LAT cycles after the load.
- R7: `resolve_valid` with `resolve_tag` acts as one more wakeup broadcast in that cycle.
- R8: `miss_valid` is raised MISS_DELAY cycles after the missed load was selected. In that cycle:
  - nothing is selected;
  - pending load broadcasts are discarded;
  - every instruction selected in the MISS_DELAY-1 cycles after the load returns to waiting, whether it depends on the load or not, and a still-ready one is selected again in the next cycle.
- R9: The miss clears every source ready bit whose tag equals `miss_tag` or equals the destination of a replayed instruction. Such a source waits for a new broadcast.
- R10: A slot stays occupied through the MISS_DELAY cycles after its selection and is freed at the following edge. `iq_full` is high exactly while all N slots are occupied.
- R11: A dispatch offered while `iq_full` is high is dropped, and that instruction never issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch one instruction this cycle |
| disp_src0 | input | TAG_W | First source tag |
| disp_src0_rdy | input | 1 | First source already available |
| disp_src1 | input | TAG_W | Second source tag |
| disp_src1_rdy | input | 1 | Second source already available |
| disp_dst | input | TAG_W | Destination tag |
| disp_load | input | 1 | Instruction is a load |
| miss_valid | input | 1 | A load selected MISS_DELAY cycles ago missed |
| miss_tag | input | TAG_W | Destination tag of the missed load |
| resolve_valid | input | 1 | Late data for a tag has arrived |
| resolve_tag | input | TAG_W | Tag to wake on resolve |
| iss_valid | output | W | Per-lane issue valid, registered |
| iss_tag | output | W*TAG_W | Per-lane destination tag of the issued instruction |
| iq_full | output | 1 | All slots occupied |

## Verification
The bench drives two collisions in the same cycle.

The first places a dispatch in the cycle of a resolve broadcast that wakes its source. The new instruction must then leave together with the older woken ones, in age order behind them.

The second arranges for a consumer to become ready exactly in the cycle the miss arrives. Its producer was selected inside the load shadow. The expected outcome is that nothing issues one cycle after the miss. The replayed independent instruction leaves one cycle after that. The consumer and its producer stay parked until the resolve, then leave on consecutive cycles. A scoreboard compares every issued tag and its cycle against this order.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE   = 2'd0,
    SLOT_WAIT   = 2'd1,
    SLOT_SHADOW = 2'd2
  } slot_state_t;
endpackage

// File: rtl/iq_select.sv
module iq_select #(
  parameter int N = 8,
  parameter int W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:0]          alloc_oh,
  input  logic [N-1:0]          live,
  input  logic [N-1:0]          req,
  output logic [N-1:0]          grant,
  output logic [W-1:0][N-1:0]   lane_oh
);
  localparam int RW = $clog2(N + 1);

  // older[i][j] set: slot i was dispatched before slot j
  logic [N-1:0][N-1:0] older;
  logic [RW-1:0]       rank [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      older <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (alloc_oh[i])      older[i][j] <= 1'b0;
          else if (alloc_oh[j]) older[i][j] <= live[i];
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      rank[i] = '0;
      for (int j = 0; j < N; j++) begin
        if (req[j] && older[j][i]) rank[i] = rank[i] + RW'(1);
      end
      grant[i] = req[i] && (rank[i] < RW'(W));
    end
    for (int l = 0; l < W; l++) begin
      for (int i = 0; i < N; i++) begin
        lane_oh[l][i] = req[i] && (rank[i] == RW'(l));
      end
    end
  end

  a_r3_grant_limit: assert property (@(posedge clk) disable iff (rst)
    $countones(grant) <= W);

  for (genvar i = 0; i < N; i++) begin : g_age_chk
    logic [N-1:0] elder;
    always_comb begin
      for (int j = 0; j < N; j++) elder[j] = older[j][i];
    end
    a_r3_oldest_first: assert property (@(posedge clk) disable iff (rst)
      grant[i] |-> ((req & ~grant & elder) == '0));
  end
endmodule

// File: rtl/iq_load_pipe.sv
module iq_load_pipe #(
  parameter int W     = 2,
  parameter int TAG_W = 6,
  parameter int LAT   = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic [W-1:0]            push_v,
  input  logic [W-1:0][TAG_W-1:0] push_tag,
  output logic [W-1:0]            out_v,
  output logic [W-1:0][TAG_W-1:0] out_tag
);
  localparam int DEPTH = LAT - 1;

  logic [DEPTH-1:0][W-1:0]            st_v;
  logic [DEPTH-1:0][W-1:0][TAG_W-1:0] st_tag;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst || flush) st_v[s] <= '0;
        else              st_v[s] <= push_v;
        st_tag[s] <= push_tag;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst || flush) st_v[s] <= '0;
        else              st_v[s] <= st_v[s-1];
        st_tag[s] <= st_tag[s-1];
      end
    end
  end

  assign out_v   = st_v[DEPTH-1] & {W{~flush}};
  assign out_tag = st_tag[DEPTH-1];
endmodule

// File: rtl/iq_entry.sv
module iq_entry
  import iq_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int NB     = 5,
  parameter int NK     = 8,
  parameter int SHADOW = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     alloc,
  input  logic [1:0][TAG_W-1:0]    alloc_src,
  input  logic [1:0]               alloc_rdy,
  input  logic [TAG_W-1:0]         alloc_dst,
  input  logic                     alloc_load,
  input  logic [NB-1:0]            bc_v,
  input  logic [NB-1:0][TAG_W-1:0] bc_tag,
  input  logic                     miss,
  input  logic [TAG_W-1:0]         miss_tag,
  input  logic [NK-1:0]            kill_v,
  input  logic [NK-1:0][TAG_W-1:0] kill_tag,
  input  logic                     grant,
  output logic                     req,
  output logic                     live,
  output logic                     rearm,
  output logic                     is_load,
  output logic [TAG_W-1:0]         dst
);
  localparam int CW = $clog2(SHADOW + 1);

  slot_state_t             state;
  logic [CW-1:0]           cnt;
  logic [1:0][TAG_W-1:0]   src_q, src_d;
  logic [1:0]              rdy_q, rdy_d, woke, dead;

  always_comb begin
    for (int o = 0; o < 2; o++) begin
      src_d[o] = alloc ? alloc_src[o] : src_q[o];
      woke[o]  = 1'b0;
      dead[o]  = miss && (src_d[o] == miss_tag);
      for (int b = 0; b < NB; b++) begin
        if (bc_v[b] && (bc_tag[b] == src_d[o])) woke[o] = 1'b1;
      end
      for (int k = 0; k < NK; k++) begin
        if (kill_v[k] && (kill_tag[k] == src_d[o])) dead[o] = 1'b1;
      end
      rdy_d[o] = ((alloc ? alloc_rdy[o] : rdy_q[o]) | woke[o]) & ~dead[o];
    end
  end

  always_ff @(posedge clk) begin
    src_q <= src_d;
    if (rst) rdy_q <= '0;
    else     rdy_q <= rdy_d;
    if (alloc) begin
      dst     <= alloc_dst;
      is_load <= alloc_load;
    end
  end

  assign rearm = (state == SLOT_SHADOW) && miss && (cnt < CW'(SHADOW));
  assign req   = (state == SLOT_WAIT) && (&rdy_q);
  assign live  = (state != SLOT_FREE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SLOT_FREE;
      cnt   <= '0;
    end else begin
      unique case (state)
        SLOT_FREE: if (alloc) state <= SLOT_WAIT;
        SLOT_WAIT: if (grant) begin
          state <= SLOT_SHADOW;
          cnt   <= CW'(1);
        end
        SLOT_SHADOW: begin
          if (rearm) begin
            state <= SLOT_WAIT;
            cnt   <= '0;
          end else if (cnt == CW'(SHADOW)) begin
            state <= SLOT_FREE;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: state <= SLOT_FREE;
      endcase
    end
  end

  a_r2_grant_when_ready: assert property (@(posedge clk) disable iff (rst)
    grant |-> (state == SLOT_WAIT && rdy_q == 2'b11));

  a_r10_hold_window: assert property (@(posedge clk) disable iff (rst)
    (state == SLOT_SHADOW && cnt < CW'(SHADOW)) |=> (state != SLOT_FREE));
endmodule

// File: rtl/spec_issue_queue.sv
module spec_issue_queue #(
  parameter int N          = 8,
  parameter int W          = 2,
  parameter int TAG_W      = 6,
  parameter int LOAD_LAT   = 3,
  parameter int MISS_DELAY = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               disp_valid,
  input  logic [TAG_W-1:0]   disp_src0,
  input  logic               disp_src0_rdy,
  input  logic [TAG_W-1:0]   disp_src1,
  input  logic               disp_src1_rdy,
  input  logic [TAG_W-1:0]   disp_dst,
  input  logic               disp_load,
  input  logic               miss_valid,
  input  logic [TAG_W-1:0]   miss_tag,
  input  logic               resolve_valid,
  input  logic [TAG_W-1:0]   resolve_tag,
  output logic [W-1:0]       iss_valid,
  output logic [W*TAG_W-1:0] iss_tag,
  output logic               iq_full
);
  localparam int NB = 2 * W + 1;

  logic [N-1:0]            ent_live, ent_req, ent_rearm, ent_load;
  logic [N-1:0][TAG_W-1:0] ent_dst;
  logic [N-1:0]            free_oh, alloc_oh, sel_req, grant;
  logic                    free_hit;
  logic [W-1:0][N-1:0]     lane_oh;
  logic [W-1:0]            lane_v, lane_ld, pipe_v;
  logic [W-1:0][TAG_W-1:0] lane_tag, pipe_tag;
  logic [NB-1:0]           bc_v;
  logic [NB-1:0][TAG_W-1:0] bc_tag;

  // lowest free slot takes the next dispatch
  always_comb begin
    free_oh  = '0;
    free_hit = 1'b0;
    for (int e = 0; e < N; e++) begin
      if (!ent_live[e] && !free_hit) begin
        free_oh[e] = 1'b1;
        free_hit   = 1'b1;
      end
    end
  end

  assign iq_full  = &ent_live;
  assign alloc_oh = (disp_valid && free_hit) ? free_oh : '0;
  assign sel_req  = ent_req & {N{~miss_valid}};

  iq_select #(.N(N), .W(W)) u_sel (
    .clk(clk), .rst(rst), .alloc_oh(alloc_oh), .live(ent_live),
    .req(sel_req), .grant(grant), .lane_oh(lane_oh)
  );

  always_comb begin
    for (int l = 0; l < W; l++) begin
      lane_v[l]   = |lane_oh[l];
      lane_tag[l] = '0;
      lane_ld[l]  = 1'b0;
      for (int e = 0; e < N; e++) begin
        if (lane_oh[l][e]) begin
          lane_tag[l] = lane_tag[l] | ent_dst[e];
          lane_ld[l]  = lane_ld[l] | ent_load[e];
        end
      end
    end
  end

  iq_load_pipe #(.W(W), .TAG_W(TAG_W), .LAT(LOAD_LAT)) u_ldp (
    .clk(clk), .rst(rst), .flush(miss_valid),
    .push_v(lane_v & lane_ld), .push_tag(lane_tag),
    .out_v(pipe_v), .out_tag(pipe_tag)
  );

  always_comb begin
    for (int l = 0; l < W; l++) begin
      bc_v[l]       = lane_v[l] & ~lane_ld[l];
      bc_tag[l]     = lane_tag[l];
      bc_v[W+l]     = pipe_v[l];
      bc_tag[W+l]   = pipe_tag[l];
    end
    bc_v[2*W]   = resolve_valid;
    bc_tag[2*W] = resolve_tag;
  end

  for (genvar e = 0; e < N; e++) begin : g_slot
    iq_entry #(.TAG_W(TAG_W), .NB(NB), .NK(N), .SHADOW(MISS_DELAY)) u_ent (
      .clk(clk), .rst(rst),
      .alloc(alloc_oh[e]),
      .alloc_src({disp_src1, disp_src0}),
      .alloc_rdy({disp_src1_rdy, disp_src0_rdy}),
      .alloc_dst(disp_dst), .alloc_load(disp_load),
      .bc_v(bc_v), .bc_tag(bc_tag),
      .miss(miss_valid), .miss_tag(miss_tag),
      .kill_v(ent_rearm), .kill_tag(ent_dst),
      .grant(grant[e]),
      .req(ent_req[e]), .live(ent_live[e]), .rearm(ent_rearm[e]),
      .is_load(ent_load[e]), .dst(ent_dst[e])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= '0;
      iss_tag   <= '0;
    end else begin
      iss_valid <= lane_v;
      for (int l = 0; l < W; l++) iss_tag[l*TAG_W +: TAG_W] <= lane_tag[l];
    end
  end

  a_r8_quiet_after_miss: assert property (@(posedge clk) disable iff (rst)
    miss_valid |=> (iss_valid == '0));

  for (genvar l = 1; l < W; l++) begin : g_lane_chk
    a_r3_lane_packing: assert property (@(posedge clk) disable iff (rst)
      iss_valid[l] |-> iss_valid[l-1]);
  end
endmodule

// File: tb/sim_spec_issue_queue.sv
`timescale 1ns/1ps
module sim_spec_issue_queue;
  localparam int N = 8, W = 2, TW = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic disp_valid = 0, disp_src0_rdy = 0, disp_src1_rdy = 0, disp_load = 0;
  logic [TW-1:0] disp_src0 = '0, disp_src1 = '0, disp_dst = '0;
  logic miss_valid = 0, resolve_valid = 0;
  logic [TW-1:0] miss_tag = '0, resolve_tag = '0;
  logic [W-1:0] iss_valid;
  logic [W*TW-1:0] iss_tag;
  logic iq_full;

  int cyc = 0, checks = 0, failures = 0;
  bit done = 0, seen_dropped = 0;

  typedef struct { int at; int tag; string req; } exp_t;
  exp_t exq[$];

  spec_issue_queue #(.N(N), .W(W), .TAG_W(TW), .LOAD_LAT(3), .MISS_DELAY(4)) u0 (
    .clk(clk), .rst(rst), .disp_valid(disp_valid),
    .disp_src0(disp_src0), .disp_src0_rdy(disp_src0_rdy),
    .disp_src1(disp_src1), .disp_src1_rdy(disp_src1_rdy),
    .disp_dst(disp_dst), .disp_load(disp_load),
    .miss_valid(miss_valid), .miss_tag(miss_tag),
    .resolve_valid(resolve_valid), .resolve_tag(resolve_tag),
    .iss_valid(iss_valid), .iss_tag(iss_tag), .iq_full(iq_full)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops the scoreboard as lanes fire
  always @(negedge clk) begin
    int t;
    exp_t e;
    if (!rst) begin
      for (int l = 0; l < W; l++) begin
        if (iss_valid[l]) begin
          t = int'(iss_tag[l*TW +: TW]);
          checks++;
          if (t == 99) seen_dropped = 1;
          if (exq.size() == 0) begin
            failures++;
            $display("FAIL R11 unexpected issue: actual tag=%0d cycle=%0d, expected none", t, cyc);
          end else begin
            e = exq.pop_front();
            if (e.tag != t || e.at != cyc) begin
              failures++;
              $display("FAIL %s lane %0d: actual tag=%0d cycle=%0d, expected tag=%0d cycle=%0d",
                       e.req, l, t, cyc, e.tag, e.at);
            end
          end
        end
      end
    end
  end

  task automatic expect_iss(input int at, input int tag, input string req);
    exp_t e;
    e.at = at; e.tag = tag; e.req = req;
    exq.push_back(e);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp_v);
    end
  endtask

  task automatic cycle();
    @(posedge clk); #1;
    disp_valid = 0; miss_valid = 0; resolve_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic disp(input int s0, input bit r0, input int s1, input bit r1,
                      input int d, input bit ld);
    disp_valid = 1; disp_src0 = TW'(s0); disp_src0_rdy = r0;
    disp_src1 = TW'(s1); disp_src1_rdy = r1; disp_dst = TW'(d); disp_load = ld;
  endtask

  task automatic resolve(input int t);
    resolve_valid = 1; resolve_tag = TW'(t);
  endtask

  task automatic miss(input int t);
    miss_valid = 1; miss_tag = TW'(t);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    int k;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    idle(2);
    // R1: reset state
    chk(iss_valid == '0, "R1", int'(iss_valid), 0);
    chk(iq_full == 1'b0, "R1", int'(iq_full), 0);

    // R7/R3/R5: resolve wakes three, a fourth dispatched in the resolve cycle
    k = cyc;
    expect_iss(k+5, 10, "R7"); expect_iss(k+5, 11, "R3");
    expect_iss(k+6, 12, "R3"); expect_iss(k+6, 13, "R5");
    disp(5, 0, 0, 1, 10, 0); cycle();
    disp(5, 0, 0, 1, 11, 0); cycle();
    disp(5, 0, 0, 1, 12, 0); cycle();
    disp(5, 0, 0, 1, 13, 0); resolve(5); cycle();
    idle(8);

    // R2/R4: back-to-back dependent chain
    k = cyc;
    expect_iss(k+2, 20, "R2"); expect_iss(k+3, 21, "R4"); expect_iss(k+4, 22, "R4");
    disp(0, 1, 0, 1, 20, 0); cycle();
    disp(20, 0, 0, 1, 21, 0); cycle();
    disp(21, 0, 0, 1, 22, 0); cycle();
    idle(8);

    // R6: load wakes its dependent after the assumed hit latency
    k = cyc;
    expect_iss(k+2, 30, "R2"); expect_iss(k+4, 32, "R2"); expect_iss(k+5, 31, "R6");
    disp(0, 1, 0, 1, 30, 1); cycle();
    disp(30, 0, 0, 1, 31, 0); cycle();
    disp(0, 1, 0, 1, 32, 0); cycle();
    idle(8);

    // R8/R9: miss replays the shadow, consumer ready in the miss cycle
    k = cyc;
    expect_iss(k+2, 40, "R8"); expect_iss(k+4, 42, "R8"); expect_iss(k+5, 41, "R6");
    expect_iss(k+7, 42, "R8"); expect_iss(k+11, 41, "R9"); expect_iss(k+12, 43, "R9");
    disp(0, 1, 0, 1, 40, 1); cycle();
    disp(40, 0, 0, 1, 41, 0); cycle();
    disp(0, 1, 0, 1, 42, 0); cycle();
    disp(41, 0, 0, 1, 43, 0); cycle();
    cycle();
    miss(40); cycle();
    idle(3);
    resolve(40); cycle();
    idle(10);

    // R10/R11: fill, drop on full, drain, slot release timing
    k = cyc;
    for (int i = 0; i < 8; i++) expect_iss(k+11+i/2, 50+i, "R3");
    for (int i = 0; i < 8; i++) begin
      disp(7, 0, 0, 1, 50+i, 0); cycle();
    end
    chk(iq_full == 1'b1, "R10", int'(iq_full), 1);
    disp(7, 0, 0, 1, 99, 0); cycle();
    resolve(7); cycle();
    idle(4);
    chk(iq_full == 1'b1, "R10", int'(iq_full), 1);
    cycle();
    chk(iq_full == 1'b0, "R10", int'(iq_full), 0);
    idle(10);
    chk(!seen_dropped, "R11", int'(seen_dropped), 0);
    chk(exq.size() == 0, "R3", exq.size(), 0);
    done = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      report();
    end
  end
endmodule